// File: doc/BRIEF.md
# Machine-mode CSR and trap unit

This block holds the control and status registers of a 32-bit integer core that runs in machine and user privilege, and it performs hardware trap entry and trap return. The core presents one CSR access per cycle: a 12-bit address, an operation (atomic swap or read-and-set), the source operand, and flags telling whether the destination or the source register is x0. The unit returns the old CSR value in the same cycle and commits the new value at the next clock edge.

The unit keeps a free-running cycle counter, a retired-instruction counter, a constant hart number, a scratch register, a trap vector base, the saved trap PC, the trap cause and the status word with the interrupt-enable and privilege stack. A write-only host register drives a data port with a one-cycle valid strobe. When the core requests an exception, or a CSR access is illegal, the unit saves the PC, the cause and the previous privilege, raises privilege to machine mode and redirects fetch to the trap vector. A trap-return redirects fetch to the saved PC and pops the privilege and enable stack.

Top module: `csr_trap_unit`

## Requirements
- R1: After reset the privilege is machine (priv_o = 2'b11), status reads 0, the trap vector reads TVEC_RESET with bits 1:0 cleared, scratch, saved PC, cause and both counters read 0, and host_valid_o is 0.
- R2: The cycle counter (0xC00) adds one on every clock edge out of reset and the retired counter (0xC02) adds one on each edge with retire_i high; both are CNT_W bits wide, wrap modulo 2^CNT_W and read zero-extended.
- R3: The cycle counter, the retired counter and the hart number (0xF14, reads HART_ID) are read-only: a read-and-set with rs1_zero_i high reads them, while a swap or a read-and-set with rs1_zero_i low is illegal and changes none of them.
- R4: Swap (csr_op_i = 2'b01) returns the old value and stores csr_wdata_i in the same operation; with rd_zero_i high the write still happens and csr_rdata_o is 0. Scratch (0x340) is a plain read/write register.
- R5: Read-and-set (csr_op_i = 2'b10) returns the old value and stores old OR csr_wdata_i; with rs1_zero_i high the register is not modified whatever csr_wdata_i holds.
- R6: The host register (0x7C0) accepts only a swap with rd_zero_i high; one cycle after such an access host_valid_o is 1 for exactly one cycle with host_data_o equal to the written data. Any other access to it is illegal.
- R7: An access to an unimplemented address, or with csr_op_i of 2'b00 or 2'b11, raises csr_illegal_o in the same cycle, writes nothing, and takes a trap with cause 2 and saved PC pc_i.
- R8: On exc_req_i (cause 2 = illegal instruction, 8 = environment call) redirect_o is 1 with redirect_pc_o = trap vector in the same cycle; at the next edge the saved PC (0x341) takes pc_i with bits 1:0 cleared, the cause (0x342) takes exc_cause_i, MPP takes the old privilege, MPIE takes MIE, MIE clears and privilege becomes machine.
- R9: On trap_ret_i redirect_o is 1 with redirect_pc_o = saved PC; at the next edge privilege takes MPP, MIE takes MPIE, MPIE becomes 1 and MPP becomes user (2'b00).
- R10: A trap (exception or illegal access) takes precedence over a trap-return in the same cycle, and a CSR write is dropped in any cycle that takes a trap or a trap-return.
- R11: Status (0x300) holds only MIE at bit 3, MPIE at bit 7 and MPP at bits 12:11, other bits read 0, and an MPP write of any value other than 2'b11 stores 2'b00; the trap vector (0x305) and saved PC clear bits 1:0 on write.
- R12: Software may overwrite the saved PC before a trap-return, and the return then redirects to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | CSR access valid this cycle |
| csr_op_i | input | 2 | 01 swap, 10 read-and-set, others illegal |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | Source operand |
| rd_zero_i | input | 1 | Destination register is x0 |
| rs1_zero_i | input | 1 | Source register is x0 |
| csr_rdata_o | output | XLEN | Old CSR value |
| csr_illegal_o | output | 1 | Access is illegal, trap taken |
| pc_i | input | XLEN | PC of the instruction presented this cycle |
| retire_i | input | 1 | One instruction retires |
| exc_req_i | input | 1 | Exception request |
| exc_cause_i | input | CAUSE_W | Exception cause code |
| trap_ret_i | input | 1 | Trap-return request |
| redirect_o | output | 1 | Next PC comes from redirect_pc_o |
| redirect_pc_o | output | XLEN | Trap vector or saved PC |
| priv_o | output | 2 | Current privilege, 11 machine, 00 user |
| host_valid_o | output | 1 | Host data strobe |
| host_data_o | output | XLEN | Host data |

## Verification
The bench builds the unit with CNT_W = 8, HART_ID = 5 and TVEC_RESET = 0x100. The narrow counter lets a run of a few hundred cycles cross the wrap point of the cycle counter, the non-zero hart number tells a real read from a zero return, and the non-zero vector shows that reset loads it. The trap sequence walks the privilege stack from machine to user and back, so every field of the status word takes both values.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SWAP = 2'b01,
    OP_SET  = 2'b10,
    OP_RSVD = 2'b11
  } csr_op_e;

  localparam logic [11:0] ADDR_CYCLE    = 12'hC00;
  localparam logic [11:0] ADDR_INSTRET  = 12'hC02;
  localparam logic [11:0] ADDR_HARTID   = 12'hF14;
  localparam logic [11:0] ADDR_MSTATUS  = 12'h300;
  localparam logic [11:0] ADDR_MTVEC    = 12'h305;
  localparam logic [11:0] ADDR_MSCRATCH = 12'h340;
  localparam logic [11:0] ADDR_MEPC     = 12'h341;
  localparam logic [11:0] ADDR_MCAUSE   = 12'h342;
  localparam logic [11:0] ADDR_HOST     = 12'h7C0;

  localparam int unsigned MIE_BIT  = 3;
  localparam int unsigned MPIE_BIT = 7;
  localparam int unsigned MPP_LO   = 11;

  localparam int unsigned CAUSE_ILLEGAL = 2;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CYCLE,
    SEL_INSTRET,
    SEL_HARTID,
    SEL_MSTATUS,
    SEL_MTVEC,
    SEL_MSCRATCH,
    SEL_MEPC,
    SEL_MCAUSE,
    SEL_HOST
  } csr_sel_e;

  typedef struct packed {
    csr_sel_e sel;
    logic     illegal;
    logic     wr;
    logic     rd;
  } csr_dec_t;

  function automatic logic [1:0] legal_mpp(input logic [1:0] v);
    return (v == PRIV_M) ? PRIV_M : PRIV_U;
  endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_trap_pkg::*;
(
  input  logic        req_i,
  input  logic [1:0]  op_i,
  input  logic [11:0] addr_i,
  input  logic        rd_zero_i,
  input  logic        rs1_zero_i,
  output csr_dec_t    dec_o
);

  csr_sel_e sel;
  logic     ro, wo, op_ok, wr_try, rd_skip, bad;

  always_comb begin
    case (addr_i)
      ADDR_CYCLE:    sel = SEL_CYCLE;
      ADDR_INSTRET:  sel = SEL_INSTRET;
      ADDR_HARTID:   sel = SEL_HARTID;
      ADDR_MSTATUS:  sel = SEL_MSTATUS;
      ADDR_MTVEC:    sel = SEL_MTVEC;
      ADDR_MSCRATCH: sel = SEL_MSCRATCH;
      ADDR_MEPC:     sel = SEL_MEPC;
      ADDR_MCAUSE:   sel = SEL_MCAUSE;
      ADDR_HOST:     sel = SEL_HOST;
      default:       sel = SEL_NONE;
    endcase
  end

  assign ro      = (sel == SEL_CYCLE) || (sel == SEL_INSTRET) || (sel == SEL_HARTID);
  assign wo      = (sel == SEL_HOST);
  assign op_ok   = (op_i == OP_SWAP) || (op_i == OP_SET);
  assign wr_try  = (op_i == OP_SWAP) || ((op_i == OP_SET) && !rs1_zero_i);
  assign rd_skip = (op_i == OP_SWAP) && rd_zero_i;
  // host register is write-only: only the read-free swap form is legal
  assign bad     = (sel == SEL_NONE) || !op_ok || (ro && wr_try) || (wo && !rd_skip);

  assign dec_o.sel     = sel;
  assign dec_o.illegal = req_i && bad;
  assign dec_o.wr      = req_i && !bad && wr_try;
  assign dec_o.rd      = req_i && !bad && !rd_skip;

endmodule

// File: rtl/csr_counter.sv
module csr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_o == $past(cnt_o) + W'(1));

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));

endmodule

// File: rtl/csr_trap_ctrl.sv
module csr_trap_ctrl
  import csr_trap_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     CAUSE_W    = 5,
  parameter logic [XLEN-1:0] TVEC_RESET = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               ret_i,
  input  logic               wr_i,
  input  csr_sel_e           sel_i,
  input  logic [XLEN-1:0]    wdata_i,
  output logic [1:0]         priv_o,
  output logic [XLEN-1:0]    mstatus_o,
  output logic [XLEN-1:0]    mtvec_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    mcause_o
);

  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  logic [1:0]         priv_q, mpp_q;
  logic               mie_q, mpie_q;
  logic [XLEN-1:0]    mtvec_q, mepc_q;
  logic [CAUSE_W-1:0] mcause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q   <= PRIV_M;
      mpp_q    <= PRIV_U;
      mie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      mtvec_q  <= TVEC_RESET & ALIGN_MASK;
      mepc_q   <= '0;
      mcause_q <= '0;
    end else if (trap_i) begin
      mepc_q   <= pc_i & ALIGN_MASK;
      mcause_q <= cause_i;
      mpp_q    <= priv_q;
      mpie_q   <= mie_q;
      mie_q    <= 1'b0;
      priv_q   <= PRIV_M;
    end else if (ret_i) begin
      priv_q   <= mpp_q;
      mie_q    <= mpie_q;
      mpie_q   <= 1'b1;
      mpp_q    <= PRIV_U;
    end else if (wr_i) begin
      case (sel_i)
        SEL_MSTATUS: begin
          mie_q  <= wdata_i[MIE_BIT];
          mpie_q <= wdata_i[MPIE_BIT];
          mpp_q  <= legal_mpp(wdata_i[MPP_LO+:2]);
        end
        SEL_MTVEC:  mtvec_q  <= wdata_i & ALIGN_MASK;
        SEL_MEPC:   mepc_q   <= wdata_i & ALIGN_MASK;
        SEL_MCAUSE: mcause_q <= wdata_i[CAUSE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    mstatus_o               = '0;
    mstatus_o[MIE_BIT]      = mie_q;
    mstatus_o[MPIE_BIT]     = mpie_q;
    mstatus_o[MPP_LO+:2]    = mpp_q;
  end

  assign priv_o   = priv_q;
  assign mtvec_o  = mtvec_q;
  assign mepc_o   = mepc_q;
  assign mcause_o = XLEN'(mcause_q);

  p_trap_stack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> priv_q == PRIV_M && mpp_q == $past(priv_q) && mpie_q == $past(mie_q) && !mie_q);

  p_trap_pc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> mepc_q == ($past(pc_i) & ALIGN_MASK) && mcause_q == $past(cause_i));

  p_ret_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !trap_i |=> priv_q == $past(mpp_q) && mie_q == $past(mpie_q) && mpie_q && mpp_q == PRIV_U);

  p_priv_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_q == PRIV_U || priv_q == PRIV_M) && (mpp_q == PRIV_U || mpp_q == PRIV_M));

  p_align_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mtvec_q[1:0] == 2'b00 && mepc_q[1:0] == 2'b00);

endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
  import csr_trap_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     CNT_W      = 32,
  parameter int unsigned     CAUSE_W    = 5,
  parameter int unsigned     HART_ID    = 0,
  parameter logic [XLEN-1:0] TVEC_RESET = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_req_i,
  input  logic [1:0]         csr_op_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic               rd_zero_i,
  input  logic               rs1_zero_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               csr_illegal_o,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               retire_i,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               trap_ret_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [1:0]         priv_o,
  output logic               host_valid_o,
  output logic [XLEN-1:0]    host_data_o
);

  localparam int unsigned N_CNT  = 2;
  localparam int unsigned CYC_IX = 0;
  localparam int unsigned RET_IX = 1;

  csr_dec_t           dec;
  logic [N_CNT-1:0]   cnt_inc;
  logic [CNT_W-1:0]   cnt_val [N_CNT];
  logic [XLEN-1:0]    old_val, new_val;
  logic [XLEN-1:0]    mstatus_w, mtvec_w, mepc_w, mcause_w;
  logic [XLEN-1:0]    mscratch_q, host_data_q;
  logic               host_valid_q;
  logic               trap_take, ret_take, commit;
  logic [CAUSE_W-1:0] trap_cause;

  csr_decode u_decode (
    .req_i      (csr_req_i),
    .op_i       (csr_op_i),
    .addr_i     (csr_addr_i),
    .rd_zero_i  (rd_zero_i),
    .rs1_zero_i (rs1_zero_i),
    .dec_o      (dec)
  );

  assign cnt_inc[CYC_IX] = 1'b1;
  assign cnt_inc[RET_IX] = retire_i;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    csr_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cnt_inc[g]),
      .cnt_o  (cnt_val[g])
    );
  end

  // trap beats trap-return; either one drops the CSR write
  assign trap_take  = exc_req_i || dec.illegal;
  assign trap_cause = exc_req_i ? exc_cause_i : CAUSE_W'(CAUSE_ILLEGAL);
  assign ret_take   = trap_ret_i && !trap_take;
  assign commit     = dec.wr && !trap_take && !trap_ret_i;

  csr_trap_ctrl #(
    .XLEN       (XLEN),
    .CAUSE_W    (CAUSE_W),
    .TVEC_RESET (TVEC_RESET)
  ) u_trap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trap_i    (trap_take),
    .cause_i   (trap_cause),
    .pc_i      (pc_i),
    .ret_i     (ret_take),
    .wr_i      (commit),
    .sel_i     (dec.sel),
    .wdata_i   (new_val),
    .priv_o    (priv_o),
    .mstatus_o (mstatus_w),
    .mtvec_o   (mtvec_w),
    .mepc_o    (mepc_w),
    .mcause_o  (mcause_w)
  );

  always_comb begin
    case (dec.sel)
      SEL_CYCLE:    old_val = XLEN'(cnt_val[CYC_IX]);
      SEL_INSTRET:  old_val = XLEN'(cnt_val[RET_IX]);
      SEL_HARTID:   old_val = XLEN'(HART_ID);
      SEL_MSTATUS:  old_val = mstatus_w;
      SEL_MTVEC:    old_val = mtvec_w;
      SEL_MSCRATCH: old_val = mscratch_q;
      SEL_MEPC:     old_val = mepc_w;
      SEL_MCAUSE:   old_val = mcause_w;
      default:      old_val = '0;
    endcase
  end

  assign new_val     = (csr_op_i == OP_SWAP) ? csr_wdata_i : (old_val | csr_wdata_i);
  assign csr_rdata_o = dec.rd ? old_val : '0;
  assign csr_illegal_o = dec.illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mscratch_q   <= '0;
      host_valid_q <= 1'b0;
      host_data_q  <= '0;
    end else begin
      host_valid_q <= commit && (dec.sel == SEL_HOST);
      if (commit && dec.sel == SEL_MSCRATCH) mscratch_q  <= new_val;
      if (commit && dec.sel == SEL_HOST)     host_data_q <= new_val;
    end
  end

  assign host_valid_o  = host_valid_q;
  assign host_data_o   = host_data_q;
  assign redirect_o    = trap_take || ret_take;
  assign redirect_pc_o = trap_take ? mtvec_w : mepc_w;

  p_rdzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && csr_op_i == OP_SWAP && rd_zero_i |-> csr_rdata_o == '0);

  p_ro_illegal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_req_i && csr_op_i == OP_SWAP &&
    (csr_addr_i == ADDR_CYCLE || csr_addr_i == ADDR_INSTRET || csr_addr_i == ADDR_HARTID)
    |-> csr_illegal_o);

  p_illegal_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o && !exc_req_i |=> mcause_w == XLEN'(CAUSE_ILLEGAL));

  p_host_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_valid_o |-> $past(csr_req_i && csr_addr_i == ADDR_HOST && !csr_illegal_o &&
                           !exc_req_i && !trap_ret_i));

  p_trap_vec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |-> redirect_o && redirect_pc_o == mtvec_w);

  p_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i || trap_ret_i) |=> $stable(mscratch_q) && !host_valid_o);

endmodule

// File: tb/csr_trap_unit_bench.sv
module csr_trap_unit_bench;
  import csr_trap_pkg::*;

  localparam int unsigned XLEN  = 32;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned CW    = 5;
  localparam int unsigned HID   = 5;
  localparam logic [31:0] TVEC0 = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_req = 1'b0;
  logic [1:0] csr_op = 2'b00;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic rd_zero = 1'b0, rs1_zero = 1'b0;
  logic [31:0] csr_rdata;
  logic csr_illegal;
  logic [31:0] pc = '0;
  logic retire = 1'b0, exc_req = 1'b0, trap_ret = 1'b0;
  logic [CW-1:0] exc_cause = '0;
  logic redirect;
  logic [31:0] redirect_pc;
  logic [1:0] priv;
  logic host_valid;
  logic [31:0] host_data;

  int n_checks = 0, n_fail = 0, bench_cyc = 0;
  bit done = 1'b0;

  logic [31:0] s_rdata, s_rpc;
  logic s_ill, s_redir;
  int s_cyc;
  logic [31:0] scratch_exp;

  csr_trap_unit #(
    .XLEN(XLEN), .CNT_W(CNT_W), .CAUSE_W(CW), .HART_ID(HID), .TVEC_RESET(TVEC0)
  ) u_csr_trap_unit (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(csr_req), .csr_op_i(csr_op),
    .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .rd_zero_i(rd_zero),
    .rs1_zero_i(rs1_zero), .csr_rdata_o(csr_rdata), .csr_illegal_o(csr_illegal),
    .pc_i(pc), .retire_i(retire), .exc_req_i(exc_req), .exc_cause_i(exc_cause),
    .trap_ret_i(trap_ret), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .priv_o(priv), .host_valid_o(host_valid), .host_data_o(host_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) bench_cyc++;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic req, input logic [1:0] op, input logic [11:0] addr,
                      input logic [31:0] wd, input logic rd0, input logic rs10,
                      input logic exc, input logic [CW-1:0] cause, input logic ret,
                      input logic [31:0] pcv);
    @(negedge clk);
    csr_req = req; csr_op = op; csr_addr = addr; csr_wdata = wd;
    rd_zero = rd0; rs1_zero = rs10; exc_req = exc; exc_cause = cause;
    trap_ret = ret; pc = pcv;
    #1;
    s_rdata = csr_rdata; s_ill = csr_illegal; s_redir = redirect;
    s_rpc = redirect_pc; s_cyc = bench_cyc;
    @(negedge clk);
    csr_req = 1'b0; csr_op = 2'b00; exc_req = 1'b0; trap_ret = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    step(1'b1, OP_SET, a, 32'h0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 32'h0);
    v = s_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, OP_SWAP, a, d, 1'b1, 1'b0, 1'b0, '0, 1'b0, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 priv", {30'b0, priv}, 32'h3);
    check("R1 host_valid", {31'b0, host_valid}, 32'h0);
    rd(ADDR_MSTATUS, v);  check("R1 mstatus", v, 32'h0);
    rd(ADDR_MTVEC, v);    check("R1 mtvec", v, TVEC0);
    rd(ADDR_MSCRATCH, v); check("R1 mscratch", v, 32'h0);
    rd(ADDR_MEPC, v);     check("R1 mepc", v, 32'h0);
    rd(ADDR_MCAUSE, v);   check("R1 mcause", v, 32'h0);
    rd(ADDR_INSTRET, v);  check("R1 instret", v, 32'h0);
    rd(ADDR_CYCLE, v);    check("R1 cycle", v, s_cyc & 32'hFF);
    rd(ADDR_HARTID, v);   check("R3 hartid read", v, HID);
  endtask

  task automatic t_counters;
    logic [31:0] c0, c1, i0, i1;
    int b0;
    rd(ADDR_CYCLE, c0); b0 = s_cyc;
    repeat (300) @(negedge clk);
    rd(ADDR_CYCLE, c1);
    check("R2 cycle wrap", c1, (c0 + (s_cyc - b0)) & 32'hFF);
    rd(ADDR_INSTRET, i0);
    @(negedge clk); retire = 1'b1;
    repeat (5) @(negedge clk); retire = 1'b0;
    repeat (3) @(negedge clk);
    rd(ADDR_INSTRET, i1);
    check("R2 instret count", i1, (i0 + 5) & 32'hFF);
  endtask

  task automatic t_read_only;
    logic [31:0] v, i0;
    step(1'b1, OP_SWAP, ADDR_CYCLE, 32'h55, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h400);
    check("R3 swap cycle illegal", {31'b0, s_ill}, 32'h1);
    check("R7 illegal redirect", {31'b0, s_redir}, 32'h1);
    check("R7 illegal vector", s_rpc, TVEC0);
    rd(ADDR_MCAUSE, v); check("R7 mcause", v, 32'h2);
    rd(ADDR_MEPC, v);   check("R7 mepc", v, 32'h400);
    step(1'b1, OP_SET, ADDR_HARTID, 32'hF0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R3 set hartid illegal", {31'b0, s_ill}, 32'h1);
    rd(ADDR_HARTID, v); check("R3 hartid unchanged", v, HID);
    rd(ADDR_INSTRET, i0);
    step(1'b1, OP_SET, ADDR_INSTRET, 32'h0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R3 set instret illegal", {31'b0, s_ill}, 32'h1);
    rd(ADDR_INSTRET, v); check("R3 instret unchanged", v, i0);
  endtask

  task automatic t_swap;
    logic [31:0] v;
    step(1'b1, OP_SWAP, ADDR_MSCRATCH, 32'hA5A5_0001, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R4 swap old", s_rdata, 32'h0);
    step(1'b1, OP_SWAP, ADDR_MSCRATCH, 32'h5A5A_0002, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R4 swap returns previous", s_rdata, 32'hA5A5_0001);
    step(1'b1, OP_SWAP, ADDR_MSCRATCH, 32'h1234_5600, 1'b1, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R4 rd x0 rdata zero", s_rdata, 32'h0);
    check("R4 rd x0 legal", {31'b0, s_ill}, 32'h0);
    rd(ADDR_MSCRATCH, v); check("R4 rd x0 still writes", v, 32'h1234_5600);
    scratch_exp = 32'h1234_5600;
  endtask

  task automatic t_set;
    logic [31:0] v;
    step(1'b1, OP_SET, ADDR_MSCRATCH, 32'h0000_00F0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R5 set old", s_rdata, scratch_exp);
    scratch_exp = scratch_exp | 32'hF0;
    rd(ADDR_MSCRATCH, v); check("R5 set or", v, scratch_exp);
    step(1'b1, OP_SET, ADDR_MSCRATCH, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, '0, 1'b0, 32'h0);
    check("R5 rs1 x0 read", s_rdata, scratch_exp);
    rd(ADDR_MSCRATCH, v); check("R5 rs1 x0 no modify", v, scratch_exp);
  endtask

  task automatic t_host;
    step(1'b1, OP_SWAP, ADDR_HOST, 32'h0000_CAFE, 1'b1, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R6 host write legal", {31'b0, s_ill}, 32'h0);
    check("R6 host valid", {31'b0, host_valid}, 32'h1);
    check("R6 host data", host_data, 32'h0000_CAFE);
    @(negedge clk);
    check("R6 host valid one cycle", {31'b0, host_valid}, 32'h0);
    step(1'b1, OP_SET, ADDR_HOST, 32'h0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 32'h0);
    check("R6 host read illegal", {31'b0, s_ill}, 32'h1);
    step(1'b1, OP_SWAP, ADDR_HOST, 32'h77, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R6 host swap with read illegal", {31'b0, s_ill}, 32'h1);
    check("R6 no strobe on illegal", {31'b0, host_valid}, 32'h0);
  endtask

  task automatic t_unimpl;
    logic [31:0] v;
    step(1'b1, OP_SET, 12'h123, 32'h0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 32'h500);
    check("R7 unimplemented illegal", {31'b0, s_ill}, 32'h1);
    rd(ADDR_MEPC, v); check("R7 unimplemented mepc", v, 32'h500);
    step(1'b1, OP_NONE, ADDR_MSCRATCH, 32'hDEAD_0000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R7 op 00 illegal", {31'b0, s_ill}, 32'h1);
    step(1'b1, OP_RSVD, ADDR_MSCRATCH, 32'hBEEF_0000, 1'b0, 1'b0, 1'b0, '0, 1'b0, 32'h0);
    check("R7 op 11 illegal", {31'b0, s_ill}, 32'h1);
    rd(ADDR_MSCRATCH, v); check("R7 no write on illegal", v, scratch_exp);
  endtask

  task automatic t_legalize;
    logic [31:0] v;
    wr(ADDR_MTVEC, 32'h0000_0203); rd(ADDR_MTVEC, v); check("R11 mtvec align", v, 32'h200);
    wr(ADDR_MSTATUS, 32'h0000_0800); rd(ADDR_MSTATUS, v); check("R11 mpp 01 to user", v, 32'h0);
    wr(ADDR_MSTATUS, 32'hFFFF_FFFF); rd(ADDR_MSTATUS, v); check("R11 mstatus fields", v, 32'h1888);
    wr(ADDR_MEPC, 32'h0000_1237); rd(ADDR_MEPC, v); check("R11 mepc align", v, 32'h1234);
  endtask

  task automatic t_trap_flow;
    logic [31:0] v;
    wr(ADDR_MSTATUS, 32'h0000_0080);
    step(1'b0, OP_NONE, 12'h0, 32'h0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 32'h0);
    check("R9 ret redirect", {31'b0, s_redir}, 32'h1);
    check("R9 ret target", s_rpc, 32'h1234);
    check("R9 ret priv user", {30'b0, priv}, 32'h0);
    rd(ADDR_MSTATUS, v); check("R9 ret stack pop", v, 32'h88);
    step(1'b0, OP_NONE, 12'h0, 32'h0, 1'b0, 1'b0, 1'b1, 5'd8, 1'b0, 32'h2006);
    check("R8 exc redirect", {31'b0, s_redir}, 32'h1);
    check("R8 exc vector", s_rpc, 32'h200);
    check("R8 exc priv machine", {30'b0, priv}, 32'h3);
    rd(ADDR_MSTATUS, v); check("R8 exc stack push", v, 32'h80);
    rd(ADDR_MEPC, v);    check("R8 exc mepc", v, 32'h2004);
    rd(ADDR_MCAUSE, v);  check("R8 exc cause ecall", v, 32'h8);
    wr(ADDR_MEPC, v + 32'h0);
    wr(ADDR_MEPC, 32'h2008);
    step(1'b0, OP_NONE, 12'h0, 32'h0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 32'h0);
    check("R12 resume after emulation", s_rpc, 32'h2008);
    check("R12 priv back to user", {30'b0, priv}, 32'h0);
    rd(ADDR_MSTATUS, v); check("R12 mstatus after ret", v, 32'h88);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    step(1'b1, OP_SWAP, ADDR_MSCRATCH, 32'h1111, 1'b1, 1'b0, 1'b1, 5'd8, 1'b1, 32'h3000);
    check("R10 exc beats ret", s_rpc, 32'h200);
    check("R10 exc priv", {30'b0, priv}, 32'h3);
    rd(ADDR_MSCRATCH, v); check("R10 exc drops write", v, scratch_exp);
    rd(ADDR_MEPC, v);     check("R10 exc mepc", v, 32'h3000);
    step(1'b1, OP_SWAP, ADDR_MSCRATCH, 32'h2222, 1'b1, 1'b0, 1'b0, '0, 1'b1, 32'h0);
    check("R10 ret target", s_rpc, 32'h3000);
    rd(ADDR_MSCRATCH, v); check("R10 ret drops write", v, scratch_exp);
    check("R10 ret priv user", {30'b0, priv}, 32'h0);
    step(1'b1, OP_SET, 12'h123, 32'h0, 1'b0, 1'b1, 1'b0, '0, 1'b1, 32'h4000);
    check("R10 illegal beats ret", s_rpc, 32'h200);
    rd(ADDR_MCAUSE, v); check("R10 illegal cause", v, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counters();
    t_read_only();
    t_swap();
    t_set();
    t_host();
    t_unimpl();
    t_legalize();
    t_trap_flow();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule